// File: doc/BRIEF.md
# Masked Control Character Matcher

This block sits on the receive side of a serial character path. Each byte it accepts is tested against a small table of programmable control codes. One mask is shared by all table entries, so a single entry can stand for a whole class of codes by ignoring selected bit positions.

A byte that hits the table is kept out of the data stream. It is latched in a capture register, the number of the entry that hit is recorded, and an interrupt line is raised. Every other byte goes on to the output stream one cycle after it is accepted.

The table and the mask are loaded through a plain write port. Bytes enter and leave through valid/ready handshakes:
- An input byte is taken on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the one-deep output register is empty or is being drained in the same cycle (`out_ready` high).
- While `out_valid` is high and `out_ready` is low, the output byte holds and no new byte is accepted.
- A byte that hits the table is accepted under the same rule, even though it produces no output.

Top module: `ctlchar_filter`

## Requirements
- R1: After reset `irq`, `overrun` and `out_valid` are 0, `match_idx` and `capt_char` are 0, `in_ready` is 1, every table entry is invalid and the mask is all ones, so every byte passes through.
- R2: An accepted byte that hits no entry appears on `out_data` with `out_valid` high in the cycle after acceptance. Byte order is preserved.
- R3: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While that stall lasts, `out_valid` stays high and `out_data` stays stable.
- R4: Entry i hits byte b when `((b ^ char_i) & mask) == 0`. A mask bit of 1 compares that bit position and a mask bit of 0 ignores it.
- R5: `cfg_wdata[8]` is the valid bit of an entry. Entry i takes part in matching only when entries 0 to i are all valid, so scanning stops at the first invalid entry.
- R6: When several eligible entries hit, the lowest-numbered one wins, and its number appears on `match_idx`.
- R7: A hitting byte never shows up on the output stream. From the cycle after acceptance, `capt_char` holds that byte and `match_idx` holds the winning entry. Each new hit overwrites both.
- R8: `irq` rises in the cycle after a hitting byte is accepted and stays high until a cycle with `irq_clr` high. If a hit and `irq_clr` fall in the same cycle, `irq` stays set.
- R9: `overrun` is set by a hit accepted while `irq` is already high. It is cleared by `irq_clr`, except that a new overrun in the same cycle wins. `overrun` is never high while `irq` is low.
- R10: A write with `cfg_we` high loads entry `cfg_addr` for addresses 0 to 7 and loads the mask from `cfg_wdata[7:0]` at address 8. Writes to higher addresses change nothing. A write takes effect for bytes accepted after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table or mask write strobe |
| cfg_addr | input | 4 | 0-7 select an entry, 8 selects the mask |
| cfg_wdata | input | 9 | Bit 8 is the entry valid bit, bits 7:0 the code or mask |
| in_valid | input | 1 | Received byte present |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Received byte |
| out_valid | output | 1 | Pass-through byte present |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Pass-through byte |
| irq_clr | input | 1 | Acknowledge: clears `irq` and `overrun` |
| irq | output | 1 | Control character seen, pending |
| overrun | output | 1 | A hit arrived while `irq` was pending |
| match_idx | output | 3 | Entry number of the last hit |
| capt_char | output | 8 | Last byte that hit the table |

## Verification
Two things can coincide in one cycle: a hitting byte being accepted and the host acknowledging the interrupt with `irq_clr`. This is the case where set and clear must resolve the right way for both `irq` and `overrun`.

The bench provokes it in a directed step:
- it first leaves an interrupt pending;
- it then drives a table hit in the same cycle as `irq_clr`, and expects `irq` and `overrun` to stay set;
- a lone `irq_clr` follows, and both must drop.

Random traffic later mixes acknowledges, hits and output stalls freely. On every clock, a behavioural model judges each overlap together with the in-flight pass-through byte.

// File: rtl/ctlchar_pkg.sv
package ctlchar_pkg;
  parameter int unsigned DEF_ENTRIES = 8;
  parameter int unsigned DEF_CHAR_W  = 8;

  typedef struct packed {
    logic pend;
    logic ovr;
  } irq_state_t;
endpackage

// File: rtl/ctlchar_table.sv
module ctlchar_table #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned CHAR_W  = 8,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [CHAR_W:0]                 wdata,
  output logic [ENTRIES-1:0]              ent_valid,
  output logic [ENTRIES-1:0][CHAR_W-1:0]  ent_char,
  output logic [CHAR_W-1:0]               mask
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_char[g]  <= '0;
      end else if (we && addr == ADDR_W'(g)) begin
        ent_valid[g] <= wdata[CHAR_W];
        ent_char[g]  <= wdata[CHAR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               mask <= '1;
    else if (we && addr == ADDR_W'(ENTRIES)) mask <= wdata[CHAR_W-1:0];
  end
endmodule

// File: rtl/ctlchar_match.sv
module ctlchar_match #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned CHAR_W  = 8,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [CHAR_W-1:0]               byte_in,
  input  logic [ENTRIES-1:0]              ent_valid,
  input  logic [ENTRIES-1:0][CHAR_W-1:0]  ent_char,
  input  logic [CHAR_W-1:0]               mask,
  output logic                            hit,
  output logic [IDX_W-1:0]                idx
);
  logic [ENTRIES-1:0] live;
  logic [ENTRIES-1:0] cand;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    if (g == 0) begin : g_first
      assign live[g] = ent_valid[g];
    end else begin : g_rest
      assign live[g] = live[g-1] & ent_valid[g];
    end
    assign cand[g] = live[g] & (((byte_in ^ ent_char[g]) & mask) == '0);
  end

  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |cand;
endmodule

// File: rtl/ctlchar_capture.sv
module ctlchar_capture
  import ctlchar_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CHAR_W-1:0] byte_in,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              ack,
  output logic              irq,
  output logic              overrun,
  output logic [CHAR_W-1:0] capt,
  output logic [IDX_W-1:0]  idx_q
);
  irq_state_t st_q, st_d;

  always_comb begin
    st_d.pend = take | (st_q.pend & ~ack);
    st_d.ovr  = (take & st_q.pend) | (st_q.ovr & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      capt  <= '0;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        capt  <= byte_in;
        idx_q <= idx_in;
      end
    end
  end

  assign irq     = st_q.pend;
  assign overrun = st_q.ovr;
endmodule

// File: rtl/ctlchar_filter.sv
module ctlchar_filter
  import ctlchar_pkg::*;
#(
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  parameter int unsigned CHAR_W  = DEF_CHAR_W,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned ADDR_W = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CHAR_W:0]   cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHAR_W-1:0] out_data,
  input  logic              irq_clr,
  output logic              irq,
  output logic              overrun,
  output logic [IDX_W-1:0]  match_idx,
  output logic [CHAR_W-1:0] capt_char
);
  logic [ENTRIES-1:0]             ent_valid;
  logic [ENTRIES-1:0][CHAR_W-1:0] ent_char;
  logic [CHAR_W-1:0]              mask;
  logic                           hit;
  logic [IDX_W-1:0]               hit_idx;
  logic                           accept;

  ctlchar_table #(.ENTRIES(ENTRIES), .CHAR_W(CHAR_W), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ent_valid(ent_valid), .ent_char(ent_char), .mask(mask)
  );

  ctlchar_match #(.ENTRIES(ENTRIES), .CHAR_W(CHAR_W)) u_match (
    .byte_in(in_data), .ent_valid(ent_valid), .ent_char(ent_char), .mask(mask),
    .hit(hit), .idx(hit_idx)
  );

  ctlchar_capture #(.CHAR_W(CHAR_W), .IDX_W(IDX_W)) u_capt (
    .clk(clk), .rst_n(rst_n), .take(accept & hit), .byte_in(in_data),
    .idx_in(hit_idx), .ack(irq_clr), .irq(irq), .overrun(overrun),
    .capt(capt_char), .idx_q(match_idx)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept && !hit) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ctlchar_filter_chk.sv
module ctlchar_filter_chk #(
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CHAR_W-1:0] out_data,
  input logic              irq_clr,
  input logic              irq,
  input logic              overrun
);
  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R3
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  // R9
  ovr_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> irq);

  // R9
  ovr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(irq));
endmodule

bind ctlchar_filter ctlchar_filter_chk #(.CHAR_W(CHAR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .irq_clr(irq_clr),
  .irq(irq), .overrun(overrun)
);

// File: tb/ctlchar_filter_tb.sv
module ctlchar_filter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [8:0] cfg_wdata = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       out_ready = 1'b1;
  logic       irq_clr = 1'b0;
  logic       in_ready, out_valid, irq, overrun;
  logic [7:0] out_data, capt_char;
  logic [2:0] match_idx;

  int vectors = 0;
  int miscmp  = 0;

  always #5 clk = ~clk;

  ctlchar_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .irq_clr(irq_clr), .irq(irq), .overrun(overrun),
    .match_idx(match_idx), .capt_char(capt_char)
  );

  // behavioural reference state
  bit       m_vld[8];
  bit [7:0] m_chr[8];
  bit [7:0] m_mask = 8'hFF;
  bit       m_ov = 0, m_irq = 0, m_ovr = 0;
  bit [7:0] m_od = 0, m_capt = 0;
  bit [2:0] m_idx = 0;
  byte unsigned exp_q[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3", "in_ready", in_ready, (!m_ov || out_ready));
    chk("R2/R7", "out_valid", out_valid, m_ov);
    if (m_ov) chk("R2", "out_data", out_data, m_od);
    chk("R8", "irq", irq, m_irq);
    chk("R9", "overrun", overrun, m_ovr);
    chk("R6", "match_idx", match_idx, m_idx);
    chk("R7", "capt_char", capt_char, m_capt);
  endtask

  // R4 R5 R6: scan from entry 0, stop at the first invalid one
  function automatic int lookup(input bit [7:0] b);
    for (int i = 0; i < 8; i++) begin
      if (!m_vld[i]) return -1;
      if (((b ^ m_chr[i]) & m_mask) == 8'h00) return i;
    end
    return -1;
  endfunction

  task automatic tick(input bit we, input bit [3:0] a, input bit [8:0] wd,
                      input bit iv, input bit [7:0] id, input bit ordy, input bit clr);
    bit rdy, acc;
    int h;
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    in_valid = iv; in_data = id; out_ready = ordy; irq_clr = clr;
    #1;
    rdy = !m_ov || ordy;
    chk("R3", "in_ready", in_ready, rdy);
    if (out_valid && ordy) begin
      if (exp_q.size() == 0) chk("R2", "unexpected out byte", out_data, -1);
      else chk("R2", "stream order", out_data, exp_q.pop_front());
    end
    acc = iv && rdy;
    h = acc ? lookup(id) : -1;
    // output register
    if (acc && h < 0) begin m_ov = 1; m_od = id; exp_q.push_back(id); end
    else if (ordy) m_ov = 0;
    // R8 R9: set wins over acknowledge
    if (h >= 0) begin
      m_ovr = m_irq | (m_ovr & !clr);
      m_irq = 1; m_capt = id; m_idx = 3'(h);
    end else begin
      m_irq = m_irq & !clr; m_ovr = m_ovr & !clr;
    end
    // R10: table update after the compare
    if (we) begin
      if (a < 8) begin m_vld[a] = wd[8]; m_chr[a] = wd[7:0]; end
      else if (a == 8) m_mask = wd[7:0];
    end
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input bit [3:0] a, input bit [8:0] wd);
    tick(1, a, wd, 0, 0, 1, 0);
  endtask

  task automatic send(input bit [7:0] b);
    tick(0, 0, 0, 1, b, 1, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "irq", irq, 0);
    chk("R1", "overrun", overrun, 0);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "match_idx", match_idx, 0);
    chk("R1", "capt_char", capt_char, 0);
    // R1: empty table passes everything
    send(8'h13); send(8'h00); send(8'hFF);

    // R10: load entries, entry 3 invalid stops the scan (R5)
    wr(0, {1'b1, 8'h13});
    wr(1, {1'b1, 8'h11});
    wr(2, {1'b1, 8'h40});
    wr(3, {1'b0, 8'h55});
    wr(4, {1'b1, 8'h7E});
    wr(4'd12, {1'b1, 8'h00}); // R10: out of range, no effect
    send(8'h41); send(8'h13); // R4 exact hit entry 0 (R7, R8)
    send(8'h7E);              // R5: entry 4 behind invalid entry, passes
    send(8'h55);              // R5: invalid entry does not hit
    send(8'h11);              // R9: hit while irq pending
    tick(0, 0, 0, 0, 0, 1, 1); // R8 acknowledge
    // R4 R6: mask 0xF0 makes 0x11 hit entries 0 and 1, lowest wins
    wr(8, {1'b0, 8'hF0});
    send(8'h1A);
    // collision: hit + acknowledge in the same cycle (R8, R9)
    send(8'h4C);
    tick(0, 0, 0, 1, 8'h10, 1, 1);
    tick(0, 0, 0, 0, 0, 1, 1);
    // R3 back-pressure
    tick(0, 0, 0, 1, 8'h22, 0, 0);
    tick(0, 0, 0, 1, 8'h23, 0, 0);
    tick(0, 0, 0, 1, 8'h24, 0, 0);
    tick(0, 0, 0, 1, 8'h25, 1, 0);
    tick(0, 0, 0, 0, 0, 1, 0);
    // R10: rewrite entry 3 valid, entry 4 becomes reachable
    wr(3, {1'b1, 8'h60});
    wr(8, {1'b0, 8'hFF});
    send(8'h7E);
    tick(0, 0, 0, 0, 0, 1, 1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit we = ($urandom_range(0, 15) == 0);
      bit [7:0] b = $urandom_range(0, 3) == 0 ? m_chr[$urandom_range(0, 7)] : 8'($urandom);
      tick(we, 4'($urandom_range(0, 10)), 9'($urandom), $urandom_range(0, 3) != 0, b,
           $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0);
    end
    tick(0, 0, 0, 0, 0, 1, 0);
    tick(0, 0, 0, 0, 0, 1, 0);
    chk("R2", "leftover bytes", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule